// File: doc/BRIEF.md
# Delay Tap Sweep Calibrator

This block calibrates the read-capture delay line of a memory interface. On a start pulse it walks a 6-bit delay tap upward from 0 through 63. For each tap it puts the same value on every byte-lane tap output, waits for the delay line to settle, and then runs an external built-in self-test through a start/done handshake. The self-test returns a status word holding a done flag, a count of good runs and a count of bad runs. The block grades the tap from that word and records the lowest and highest taps that graded good.

When the last tap has been graded, the block applies a final tap to every lane. That tap is the centre of the good window, or a fixed fallback value when no tap graded good. It then raises a one-cycle done pulse. The recorded window edges and the number of good taps stay on the outputs for observation until the next run starts.

Top module: `tap_sweep_cal`

## Requirements
- R1: One run tests every tap exactly once, in ascending order from 0 to 63, so one run makes exactly 64 self-test launches.
- R2: All four lane tap outputs always carry the same value. That value is unchanged for at least one full cycle before the self-test start rises, and it does not change while start is high.
- R3: Self-test start stays high until status bit 0 (done) is seen at 1. Start drops two cycles after done first rises, once the result has been captured.
- R4: Status word layout: bit 0 is done, bits [8:1] are the good-run count, and bits [16:9] are the bad-run count. A tap grades good only when the bad-run count is 0 and the good-run count equals bits [8:1] of the run-count configuration input. A configuration of 0x10 therefore requests 8 runs.
- R5: The 7-bit first-tap output reads 127 (all ones) until a tap grades good. The first good tap of a run sets both the first-tap and last-tap outputs. Each later good tap updates only the last-tap output.
- R6: The good-tap count is cleared when a run starts and rises by one for each tap that grades good. It ranges from 0 to 64.
- R7: When no tap grades good, the final tap is 8. Otherwise the final tap is (first + last) >> 1, kept to 6 bits. Bad taps lying between first and last have no effect on it.
- R8: Busy is high from the cycle after an accepted start until the final tap is applied. Done is a one-cycle pulse in the same cycle that the final tap appears on all lanes, and busy is low in that cycle.
- R9: A start pulse that arrives while busy is ignored. The run in progress continues unchanged and still makes 64 launches.
- R10: A synchronous active-high reset returns the block to idle: all lanes at 0, start, busy and done low, first-tap 127, last-tap 0 and good-tap count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse to begin a calibration run |
| run_cfg_i | input | 9 | Run-count configuration; requested runs in bits [8:1] |
| bist_status_i | input | 17 | Self-test status: done [0], good runs [8:1], bad runs [16:9] |
| lane_tap_o | output | 24 | Four 6-bit lane taps, lane n in bits [6n+5:6n] |
| bist_start_o | output | 1 | Self-test start request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when the final tap is applied |
| first_tap_o | output | 7 | Lowest good tap, or 127 when none is found yet |
| last_tap_o | output | 6 | Highest good tap |
| pass_taps_o | output | 7 | Number of taps graded good in this run |

## Verification
The assertions on the start-release timing rely on the self-test engine keeping done high for as long as start stays high. They also rely on the engine clearing the whole status word once start falls, so that a stale done never meets a new launch. The bench's self-test model respects both rules. It answers a fixed number of cycles after start, holds its answer while start is high, and zeroes the status on the falling edge of start or on reset. Launch order, lane equality and settle time are measured by the model itself at each rising edge of start.

// File: rtl/tap_cal_pkg.sv
package tap_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_WAIT,
    ST_JUDGE,
    ST_FINISH
  } cal_state_e;

endpackage

// File: rtl/tap_status_decode.sv
module tap_status_decode #(
  parameter int CNT_W = 8
) (
  input  logic [2*CNT_W:0] status_i,
  input  logic [CNT_W:0]   cfg_i,
  output logic             done_o,
  output logic             good_o
);

  logic [CNT_W-1:0] good_runs;
  logic [CNT_W-1:0] bad_runs;
  logic [CNT_W:0]   want_runs;

  always_comb begin
    done_o    = status_i[0];
    good_runs = status_i[CNT_W:1];
    bad_runs  = status_i[2*CNT_W:CNT_W+1];
    want_runs = cfg_i >> 1;
    good_o    = (bad_runs == '0) && ({1'b0, good_runs} == want_runs);
  end

endmodule

// File: rtl/tap_window_track.sv
module tap_window_track #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W:0]   first_o,
  output logic [TAP_W-1:0] last_o,
  output logic [TAP_W:0]   count_o
);

  localparam logic [TAP_W:0] NONE_YET = '1;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      first_o <= NONE_YET;
      last_o  <= '0;
      count_o <= '0;
    end else if (upd_i) begin
      count_o <= count_o + (TAP_W+1)'(1);
      last_o  <= tap_i;
      if (first_o == NONE_YET) begin
        first_o <= {1'b0, tap_i};
      end
    end
  end

endmodule

// File: rtl/tap_lane_bank.sv
module tap_lane_bank #(
  parameter int TAP_W = 6,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [TAP_W-1:0]       val_i,
  output logic [LANES*TAP_W-1:0] lanes_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [TAP_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (load_i) begin
        lane_q <= val_i;
      end
    end
    assign lanes_o[g*TAP_W +: TAP_W] = lane_q;
  end

endmodule

// File: rtl/tap_sweep_cal.sv
module tap_sweep_cal #(
  parameter int TAP_W       = 6,
  parameter int LANES       = 4,
  parameter int CNT_W       = 8,
  parameter int DEFAULT_TAP = 8,
  parameter int SETTLE_CYC  = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [CNT_W:0]         run_cfg_i,
  input  logic [2*CNT_W:0]       bist_status_i,
  output logic [LANES*TAP_W-1:0] lane_tap_o,
  output logic                   bist_start_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [TAP_W:0]         first_tap_o,
  output logic [TAP_W-1:0]       last_tap_o,
  output logic [TAP_W:0]         pass_taps_o
);
  import tap_cal_pkg::*;

  localparam int               SC_W     = $clog2(SETTLE_CYC + 1);
  localparam logic [TAP_W-1:0] TAP_LAST = '1;
  localparam logic [TAP_W-1:0] FALLBACK = TAP_W'(DEFAULT_TAP);
  localparam logic [SC_W-1:0]  SC_INIT  = SC_W'(SETTLE_CYC - 1);

  cal_state_e       state;
  logic [TAP_W-1:0] cur_tap;
  logic [SC_W-1:0]  settle_q;
  logic             good_q;
  logic             start_q;
  logic             busy_q;
  logic             done_q;

  logic             st_done;
  logic             st_good;
  logic             trk_clr;
  logic             trk_upd;
  logic             lane_load;
  logic [TAP_W-1:0] lane_val;
  logic [TAP_W:0]   mid_sum;
  logic [TAP_W-1:0] final_tap;

  tap_status_decode #(.CNT_W(CNT_W)) u_decode (
    .status_i (bist_status_i),
    .cfg_i    (run_cfg_i),
    .done_o   (st_done),
    .good_o   (st_good)
  );

  tap_window_track #(.TAP_W(TAP_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (trk_clr),
    .upd_i   (trk_upd),
    .tap_i   (cur_tap),
    .first_o (first_tap_o),
    .last_o  (last_tap_o),
    .count_o (pass_taps_o)
  );

  tap_lane_bank #(.TAP_W(TAP_W), .LANES(LANES)) u_lanes (
    .clk     (clk),
    .rst     (rst),
    .load_i  (lane_load),
    .val_i   (lane_val),
    .lanes_o (lane_tap_o)
  );

  // Window centre; the sum carries one extra bit before the halving shift.
  always_comb begin
    mid_sum   = {1'b0, first_tap_o[TAP_W-1:0]} + {1'b0, last_tap_o};
    final_tap = (pass_taps_o == '0) ? FALLBACK : mid_sum[TAP_W:1];
  end

  always_comb begin
    trk_clr   = (state == ST_IDLE) && start_i;
    trk_upd   = (state == ST_JUDGE) && good_q;
    lane_load = 1'b0;
    lane_val  = '0;
    case (state)
      ST_IDLE:   lane_load = start_i;
      ST_JUDGE: begin
        lane_load = (cur_tap != TAP_LAST);
        lane_val  = cur_tap + TAP_W'(1);
      end
      ST_FINISH: begin
        lane_load = 1'b1;
        lane_val  = final_tap;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_tap  <= '0;
      settle_q <= '0;
      good_q   <= 1'b0;
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state    <= ST_SETTLE;
            cur_tap  <= '0;
            settle_q <= SC_INIT;
            busy_q   <= 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_q == '0) begin
            state   <= ST_WAIT;
            start_q <= 1'b1;
          end else begin
            settle_q <= settle_q - SC_W'(1);
          end
        end
        ST_WAIT: begin
          if (st_done) begin
            good_q <= st_good;
            state  <= ST_JUDGE;
          end
        end
        ST_JUDGE: begin
          start_q <= 1'b0;
          if (cur_tap == TAP_LAST) begin
            state <= ST_FINISH;
          end else begin
            cur_tap  <= cur_tap + TAP_W'(1);
            settle_q <= SC_INIT;
            state    <= ST_SETTLE;
          end
        end
        ST_FINISH: begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bist_start_o = start_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;

endmodule

// File: rtl/tap_sweep_cal_chk.sv
module tap_sweep_cal_chk #(
  parameter int TAP_W = 6,
  parameter int LANES = 4,
  parameter int CNT_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start_i,
  input logic [2*CNT_W:0]       bist_status_i,
  input logic [LANES*TAP_W-1:0] lane_tap_o,
  input logic                   bist_start_o,
  input logic                   busy_o,
  input logic                   done_o
);

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (lane_tap_o == '0 && !busy_o && !bist_start_o && !done_o));

  p_start_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bist_start_o && !bist_status_i[0]) |=> bist_start_o);

  p_start_release_r3: assert property (@(posedge clk) disable iff (rst)
    (bist_start_o && $rose(bist_status_i[0])) |=> ##1 !bist_start_o);

  p_lanes_stable_r2: assert property (@(posedge clk) disable iff (rst)
    bist_start_o |-> $stable(lane_tap_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  p_busy_origin_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

endmodule

bind tap_sweep_cal tap_sweep_cal_chk #(
  .TAP_W (TAP_W),
  .LANES (LANES),
  .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/tb_tap_sweep_cal.sv
module tb_tap_sweep_cal;

  localparam int BM_LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [8:0]  cfg = 9'h010;
  logic [16:0] bist_status = '0;
  logic [23:0] lane_tap_o;
  logic        bist_start_o, busy_o, done_o;
  logic [6:0]  first_tap_o, pass_taps_o;
  logic [5:0]  last_tap_o;

  int checks = 0, fails = 0;
  logic [63:0] good_mask = '0;
  int mode = 0;
  int tests = 0, settle_bad = 0, lane_bad = 0, order_bad = 0, exp_tap = 0;
  int stable = 0, bm_cnt = 0;
  logic [23:0] prev_lanes = '0;

  always #2 clk = ~clk;

  tap_sweep_cal dut (
    .clk (clk), .rst (rst), .start_i (start_i), .run_cfg_i (cfg),
    .bist_status_i (bist_status), .lane_tap_o (lane_tap_o),
    .bist_start_o (bist_start_o), .busy_o (busy_o), .done_o (done_o),
    .first_tap_o (first_tap_o), .last_tap_o (last_tap_o),
    .pass_taps_o (pass_taps_o)
  );

  // Status layout: {bad[7:0], good[7:0], done}
  function automatic logic [16:0] mk_status(input logic [5:0] t);
    logic [7:0] runs;
    runs = cfg[8:1];
    if (good_mask[t]) return {8'd0, runs, 1'b1};
    if (mode == 0)    return {8'd1, runs, 1'b1};
    return {8'd0, runs - 8'd1, 1'b1};
  endfunction

  // Self-test engine model, also measuring launch order, lane equality and settle time
  always @(negedge clk) begin
    if (lane_tap_o != prev_lanes) stable = 0; else stable = stable + 1;
    prev_lanes = lane_tap_o;
    if (rst || !bist_start_o) begin
      bist_status <= '0;
      bm_cnt = 0;
    end else if (!bist_status[0]) begin
      if (bm_cnt == 0) begin
        tests++;
        if (stable < 1) settle_bad++;
        for (int i = 1; i < 4; i++)
          if (lane_tap_o[i*6 +: 6] != lane_tap_o[5:0]) lane_bad++;
        if (int'(lane_tap_o[5:0]) != exp_tap) order_bad++;
        exp_tap++;
      end
      if (bm_cnt >= BM_LAT) bist_status <= mk_status(lane_tap_o[5:0]);
      else bm_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] span(input int lo, input int hi);
    logic [63:0] m = '0;
    for (int t = lo; t <= hi; t++) m[t] = 1'b1;
    return m;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic run_sweep(input logic [63:0] m, input int md, input logic [8:0] c,
                           input bit poke, input string tag);
    int f = 127, l = 0, n = 0, fin;
    for (int t = 0; t < 64; t++)
      if (m[t]) begin if (f == 127) f = t; l = t; n++; end
    fin = (n == 0) ? 8 : ((f + l) >> 1);
    good_mask = m; mode = md; cfg = c;
    tests = 0; settle_bad = 0; lane_bad = 0; order_bad = 0; exp_tap = 0;
    pulse_start();
    chk({tag, " R8 busy after start"}, busy_o, 1);
    if (poke) begin
      repeat (100) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      chk({tag, " R9 busy kept"}, busy_o, 1);
    end
    while (!done_o) @(negedge clk);
    chk({tag, " R1 launches"}, tests, 64);
    chk({tag, " R1 order"}, order_bad, 0);
    chk({tag, " R2 lanes equal"}, lane_bad, 0);
    chk({tag, " R2 settle"}, settle_bad, 0);
    chk({tag, " R5 first"}, first_tap_o, f);
    if (n > 0) chk({tag, " R5 last"}, last_tap_o, l);
    chk({tag, " R6 count"}, pass_taps_o, n);
    for (int i = 0; i < 4; i++) chk({tag, " R7 final lane"}, lane_tap_o[i*6 +: 6], fin);
    chk({tag, " R8 busy low at done"}, busy_o, 0);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, done_o, 0);
    chk({tag, " R7 final held"}, lane_tap_o[5:0], fin);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 lanes", lane_tap_o, 0);
    chk("R10 busy", busy_o, 0);
    chk("R10 done", done_o, 0);
    chk("R10 start", bist_start_o, 0);
    chk("R10 first", first_tap_o, 127);
    chk("R10 count", pass_taps_o, 0);
  endtask

  task automatic t_mid_reset();
    good_mask = span(0, 63); mode = 0; cfg = 9'h010;
    pulse_start();
    repeat (50) @(negedge clk);
    chk("R10 dirty before reset", first_tap_o, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 mid lanes", lane_tap_o, 0);
    chk("R10 mid busy", busy_o, 0);
    chk("R10 mid start", bist_start_o, 0);
    chk("R10 mid first", first_tap_o, 127);
    chk("R10 mid count", pass_taps_o, 0);
    chk("R10 mid last", last_tap_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    run_sweep(span(10, 20), 0, 9'h010, 1'b0, "window");                  // R4 R7
    run_sweep('0, 0, 9'h010, 1'b0, "none");                              // R7 fallback
    run_sweep(span(5, 5) | span(40, 41), 0, 9'h010, 1'b0, "gaps");       // R7 gaps ignored
    run_sweep(span(30, 33), 1, 9'h006, 1'b0, "mismatch");                // R4 count mismatch
    run_sweep(span(63, 63), 0, 9'h010, 1'b0, "top");
    run_sweep(span(62, 63), 0, 9'h002, 1'b0, "top2");
    run_sweep(span(0, 0), 0, 9'h010, 1'b0, "bottom");
    run_sweep(span(0, 63), 0, 9'h010, 1'b0, "all");                      // R6 count 64
    run_sweep(span(12, 50), 0, 9'h010, 1'b1, "poke");                    // R9
    t_mid_reset();
    run_sweep(span(20, 27), 0, 9'h010, 1'b0, "recover");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule